// File: doc/BRIEF.md
# Multi-Level Interrupt Dispatch Unit

This block sits beside a processor's control path and decides, on a take strobe, whether the pending interrupt level may preempt the running context. When it may, the unit saves the interrupted program counter and status word and rewrites the status word. It then redirects fetch to the matching vector in a single clock. Levels two and above are vectored per level. A level-one event is instead folded into a general exception entry: kernel, user or double, chosen from the status word's mode bits.

The unit owns the program counter, status word and vector base registers, so their reset values are defined here. The surrounding core advances the counter and rewrites the status word through simple write ports. The pending level is captured in a register one cycle before it is judged. The mask inputs are examined combinationally in the take cycle. Every vector is formed as the live vector base plus a fixed per-entry offset, so moving the base at run time moves all entry points together.

Top module: `irq_dispatch`

## Requirements
- R1: On reset, pc_o equals RESET_VEC, ps_o equals 0x1F (0x10 when HAS_INTERRUPTS is 0), vecbase_o equals VECBASE_RST, exccause_o, depc_o and all saved slots are 0, and taken_o is low. With the reset status word (interrupt level 15), no take is accepted.
- R2: A take is accepted only when all of the following hold. The registered level L lies in 1..NUM_LEVELS. L exceeds the current level. The AND of level L's mask slot (bits (L-1)*NUM_LINES upward of level_mask_i), intset_i and intenable_i is nonzero. A rejected take changes no output.
- R3: The status word holds the interrupt level in bits [3:0], the exception-mode flag in bit 4 and the user-mode flag in bit 5. The current level is bits [3:0], raised to EXCM_LEVEL when bit 4 is set.
- R4: For an accepted level L >= 2, the pre-take PC is copied to EPC slot L and the pre-take status word to EPS slot L. The new status word keeps bits [7:5], sets bit 4 and writes L into bits [3:0].
- R5: For an accepted level L >= 2, the next PC is vecbase + HIGH_OFS + (L-2)*LEVEL_STRIDE.
- R6: For an accepted level 1 with bit 4 clear and bit 5 clear, EPC slot 1 takes the PC, exccause_o becomes L1_CAUSE (4), the next PC is vecbase + KERNEL_OFS, and bit 4 of the status word is set with bits [3:0] kept.
- R7: As R6, but with bit 5 set the next PC is vecbase + USER_OFS.
- R8: For an accepted level 1 with bit 4 already set, depc_o takes the PC (EPC slot 1 when HAS_DEPC is 0), exccause_o becomes L1_CAUSE, and the next PC is vecbase + DOUBLE_OFS.
- R9: Vectors use the vector base held before the current edge. A vb_wr_i write takes effect from the next cycle and moves every vector by the same amount.
- R10: taken_o is high for exactly the one cycle after each accepted take, in which all updated values are already visible.
- R11: pc_wr_i and ps_wr_i load pc_o and ps_o on the next edge unless a take is accepted in that cycle, in which case the dispatch update wins.
- R12: The level judged on a take is the pend_level_i value sampled on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | Request to evaluate the pending level this cycle |
| pend_level_i | input | 4 | Pending interrupt level, registered each cycle |
| intset_i | input | NUM_LINES | Raised interrupt lines |
| intenable_i | input | NUM_LINES | Enabled interrupt lines |
| level_mask_i | input | NUM_LEVELS*NUM_LINES | Per-level line membership, slot L-1 for level L |
| pc_wr_i | input | 1 | Core write strobe for the PC |
| pc_wdata_i | input | ADDR_W | Core PC value |
| ps_wr_i | input | 1 | Core write strobe for the status word |
| ps_wdata_i | input | 8 | Core status word value |
| vb_wr_i | input | 1 | Vector base write strobe |
| vb_wdata_i | input | ADDR_W | Vector base value |
| pc_o | output | ADDR_W | Current / next fetch PC |
| ps_o | output | 8 | Status word |
| epc_o | output | NUM_LEVELS*ADDR_W | Saved PC per level, slot L-1 for level L |
| eps_o | output | (NUM_LEVELS-1)*8 | Saved status per level >= 2, slot L-2 |
| depc_o | output | ADDR_W | Saved PC for double exceptions |
| exccause_o | output | CAUSE_W | Exception cause |
| vecbase_o | output | ADDR_W | Vector base register |
| taken_o | output | 1 | One-cycle pulse per accepted take |

## Verification
Random traffic mixes take strobes with pending levels up to eight, including levels above the configured count. The line masks are sparse, so the AND test fails often. Status words vary the level field and both mode bits, which separates a rejection by level from a rejection by mask, and the high-level path from the three level-one routes. Directed cases cover the reset blocking level, kernel then double entry from the same pending level, user entry, exception mode raising the current level, and a base move just before a take. They also cover a take colliding with core writes and a pending level that changes in the take cycle, which tells the registered level apart from the live one.

// File: rtl/irq_dispatch_pkg.sv
`timescale 1ns/1ps
package irq_dispatch_pkg;

   localparam int PS_W        = 8;
   localparam int LVL_W       = 4;
   localparam int PS_EXCM_BIT = 4;
   localparam int PS_UM_BIT   = 5;

   typedef enum logic [2:0] {
      RT_NONE,
      RT_HIGH,
      RT_KERNEL,
      RT_USER,
      RT_DOUBLE
   } route_e;

   // effective current level: field value, lifted by exception mode
   function automatic logic [LVL_W-1:0] eff_level(input logic [PS_W-1:0] ps,
                                                   input logic [LVL_W-1:0] excm_lvl);
      logic [LVL_W-1:0] f;
      f = ps[LVL_W-1:0];
      if (ps[PS_EXCM_BIT] && (f < excm_lvl)) return excm_lvl;
      return f;
   endfunction

endpackage

// File: rtl/irq_level_gate.sv
`timescale 1ns/1ps
module irq_level_gate
   import irq_dispatch_pkg::*;
#(
   parameter int NUM_LEVELS = 6,
   parameter int NUM_LINES  = 32,
   parameter int EXCM_LEVEL = 0
) (
   input  logic                            take_i,
   input  logic [LVL_W-1:0]                level_i,
   input  logic [PS_W-1:0]                 ps_i,
   input  logic [NUM_LINES-1:0]            intset_i,
   input  logic [NUM_LINES-1:0]            intenable_i,
   input  logic [NUM_LEVELS*NUM_LINES-1:0] level_mask_i,
   output logic                            accept_o,
   output route_e                          route_o
);

   localparam logic [LVL_W-1:0] TOP_LVL  = LVL_W'(NUM_LEVELS);
   localparam logic [LVL_W-1:0] EXCM_LVL = LVL_W'(EXCM_LEVEL);

   logic [NUM_LINES-1:0] live;
   logic [NUM_LEVELS:0]  hit;

   assign live   = intset_i & intenable_i;
   assign hit[0] = 1'b0;

   for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_hit
      assign hit[l] = |(level_mask_i[(l-1)*NUM_LINES +: NUM_LINES] & live);
   end

   logic             hit_sel;
   logic             in_range;
   logic [LVL_W-1:0] cur_lvl;

   always_comb begin
      hit_sel = 1'b0;
      for (int l = 0; l <= NUM_LEVELS; l++) begin
         if (level_i == LVL_W'(l)) hit_sel = hit[l];
      end
      in_range = (level_i <= TOP_LVL);
      cur_lvl  = eff_level(ps_i, EXCM_LVL);
      accept_o = take_i && in_range && (level_i > cur_lvl) && hit_sel;
   end

   always_comb begin
      if (!accept_o)                     route_o = RT_NONE;
      else if (level_i >= LVL_W'(2))     route_o = RT_HIGH;
      else if (ps_i[PS_EXCM_BIT])        route_o = RT_DOUBLE;
      else if (ps_i[PS_UM_BIT])          route_o = RT_USER;
      else                               route_o = RT_KERNEL;
   end

endmodule

// File: rtl/irq_vector_gen.sv
`timescale 1ns/1ps
module irq_vector_gen
   import irq_dispatch_pkg::*;
#(
   parameter int                ADDR_W       = 32,
   parameter bit                RELOCATE     = 1'b1,
   parameter logic [ADDR_W-1:0] VECBASE_RST  = 'h4000_0000,
   parameter logic [ADDR_W-1:0] KERNEL_OFS   = 'h300,
   parameter logic [ADDR_W-1:0] USER_OFS     = 'h340,
   parameter logic [ADDR_W-1:0] DOUBLE_OFS   = 'h3C0,
   parameter logic [ADDR_W-1:0] HIGH_OFS     = 'h180,
   parameter logic [ADDR_W-1:0] LEVEL_STRIDE = 'h40
) (
   input  route_e            route_i,
   input  logic [LVL_W-1:0]  level_i,
   input  logic [ADDR_W-1:0] vecbase_i,
   output logic [ADDR_W-1:0] vec_o
);

   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] ofs;
   logic [LVL_W-1:0]  rank;

   // relocated form: default vector - default base + live base
   if (RELOCATE) begin : g_reloc
      assign base = vecbase_i;
   end else begin : g_fixed
      assign base = VECBASE_RST;
   end

   assign rank = level_i - LVL_W'(2);

   always_comb begin
      case (route_i)
         RT_HIGH:   ofs = HIGH_OFS + ADDR_W'(rank) * LEVEL_STRIDE;
         RT_KERNEL: ofs = KERNEL_OFS;
         RT_USER:   ofs = USER_OFS;
         RT_DOUBLE: ofs = DOUBLE_OFS;
         default:   ofs = '0;
      endcase
      vec_o = base + ofs;
   end

endmodule

// File: rtl/irq_save_bank.sv
`timescale 1ns/1ps
module irq_save_bank
   import irq_dispatch_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int NUM_LEVELS = 6,
   parameter bit HAS_DEPC   = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  route_e                           route_i,
   input  logic [LVL_W-1:0]                 level_i,
   input  logic [ADDR_W-1:0]                pc_i,
   input  logic [PS_W-1:0]                  ps_i,
   output logic [NUM_LEVELS*ADDR_W-1:0]     epc_o,
   output logic [(NUM_LEVELS-1)*PS_W-1:0]   eps_o,
   output logic [ADDR_W-1:0]                depc_o
);

   localparam bit DBL_TO_EPC1 = !HAS_DEPC;

   for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_lvl
      logic              wr_slot;
      logic [ADDR_W-1:0] epc_q;

      if (l == 1) begin : g_one
         assign wr_slot = (route_i == RT_KERNEL) || (route_i == RT_USER) ||
                          ((route_i == RT_DOUBLE) && DBL_TO_EPC1);
      end else begin : g_hi
         logic [PS_W-1:0] eps_q;
         assign wr_slot = (route_i == RT_HIGH) && (level_i == LVL_W'(l));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       eps_q <= '0;
            else if (wr_slot) eps_q <= ps_i;
         end
         assign eps_o[(l-2)*PS_W +: PS_W] = eps_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       epc_q <= '0;
         else if (wr_slot) epc_q <= pc_i;
      end
      assign epc_o[(l-1)*ADDR_W +: ADDR_W] = epc_q;
   end

   if (HAS_DEPC) begin : g_depc
      logic [ADDR_W-1:0] depc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     depc_q <= '0;
         else if (route_i == RT_DOUBLE)  depc_q <= pc_i;
      end
      assign depc_o = depc_q;
   end else begin : g_nodepc
      assign depc_o = '0;
   end

endmodule

// File: rtl/irq_dispatch.sv
`timescale 1ns/1ps
module irq_dispatch
   import irq_dispatch_pkg::*;
#(
   parameter int                ADDR_W         = 32,
   parameter int                NUM_LEVELS     = 6,
   parameter int                NUM_LINES      = 32,
   parameter int                EXCM_LEVEL     = 0,
   parameter int                CAUSE_W        = 6,
   parameter int                L1_CAUSE       = 4,
   parameter bit                HAS_INTERRUPTS = 1'b1,
   parameter bit                HAS_DEPC       = 1'b1,
   parameter bit                RELOCATE       = 1'b1,
   parameter logic [ADDR_W-1:0] RESET_VEC      = 'h5000_0000,
   parameter logic [ADDR_W-1:0] VECBASE_RST    = 'h4000_0000,
   parameter logic [ADDR_W-1:0] KERNEL_OFS     = 'h300,
   parameter logic [ADDR_W-1:0] USER_OFS       = 'h340,
   parameter logic [ADDR_W-1:0] DOUBLE_OFS     = 'h3C0,
   parameter logic [ADDR_W-1:0] HIGH_OFS       = 'h180,
   parameter logic [ADDR_W-1:0] LEVEL_STRIDE   = 'h40
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             take_i,
   input  logic [3:0]                       pend_level_i,
   input  logic [NUM_LINES-1:0]             intset_i,
   input  logic [NUM_LINES-1:0]             intenable_i,
   input  logic [NUM_LEVELS*NUM_LINES-1:0]  level_mask_i,
   input  logic                             pc_wr_i,
   input  logic [ADDR_W-1:0]                pc_wdata_i,
   input  logic                             ps_wr_i,
   input  logic [7:0]                       ps_wdata_i,
   input  logic                             vb_wr_i,
   input  logic [ADDR_W-1:0]                vb_wdata_i,
   output logic [ADDR_W-1:0]                pc_o,
   output logic [7:0]                       ps_o,
   output logic [NUM_LEVELS*ADDR_W-1:0]     epc_o,
   output logic [(NUM_LEVELS-1)*8-1:0]      eps_o,
   output logic [ADDR_W-1:0]                depc_o,
   output logic [CAUSE_W-1:0]               exccause_o,
   output logic [ADDR_W-1:0]                vecbase_o,
   output logic                             taken_o
);

   localparam logic [PS_W-1:0]    PS_RST   = HAS_INTERRUPTS ? 8'h1F : 8'h10;
   localparam logic [CAUSE_W-1:0] CAUSE_L1 = CAUSE_W'(L1_CAUSE);

   // elaboration-time parameter checks
   if (NUM_LEVELS < 2 || NUM_LEVELS > 15) begin : g_bad_levels
      $error("irq_dispatch: NUM_LEVELS must lie in 2..15");
   end
   if (EXCM_LEVEL < 0 || EXCM_LEVEL > NUM_LEVELS) begin : g_bad_excm
      $error("irq_dispatch: EXCM_LEVEL must lie in 0..NUM_LEVELS");
   end
   if (NUM_LINES < 1) begin : g_bad_lines
      $error("irq_dispatch: NUM_LINES must be positive");
   end
   if (ADDR_W < 16) begin : g_bad_addr
      $error("irq_dispatch: ADDR_W must be at least 16");
   end
   if (L1_CAUSE >= (1 << CAUSE_W)) begin : g_bad_cause
      $error("irq_dispatch: L1_CAUSE does not fit CAUSE_W");
   end

   logic [ADDR_W-1:0]  pc_q;
   logic [PS_W-1:0]    ps_q;
   logic [ADDR_W-1:0]  vb_q;
   logic [LVL_W-1:0]   pend_q;
   logic [CAUSE_W-1:0] cause_q;
   logic               taken_q;

   logic               accept;
   route_e             route;
   logic [ADDR_W-1:0]  vec;
   logic [PS_W-1:0]    ps_nxt;

   irq_level_gate #(
      .NUM_LEVELS (NUM_LEVELS),
      .NUM_LINES  (NUM_LINES),
      .EXCM_LEVEL (EXCM_LEVEL)
   ) u_gate (
      .take_i       (take_i),
      .level_i      (pend_q),
      .ps_i         (ps_q),
      .intset_i     (intset_i),
      .intenable_i  (intenable_i),
      .level_mask_i (level_mask_i),
      .accept_o     (accept),
      .route_o      (route)
   );

   irq_vector_gen #(
      .ADDR_W       (ADDR_W),
      .RELOCATE     (RELOCATE),
      .VECBASE_RST  (VECBASE_RST),
      .KERNEL_OFS   (KERNEL_OFS),
      .USER_OFS     (USER_OFS),
      .DOUBLE_OFS   (DOUBLE_OFS),
      .HIGH_OFS     (HIGH_OFS),
      .LEVEL_STRIDE (LEVEL_STRIDE)
   ) u_vec (
      .route_i   (route),
      .level_i   (pend_q),
      .vecbase_i (vb_q),
      .vec_o     (vec)
   );

   irq_save_bank #(
      .ADDR_W     (ADDR_W),
      .NUM_LEVELS (NUM_LEVELS),
      .HAS_DEPC   (HAS_DEPC)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .route_i (route),
      .level_i (pend_q),
      .pc_i    (pc_q),
      .ps_i    (ps_q),
      .epc_o   (epc_o),
      .eps_o   (eps_o),
      .depc_o  (depc_o)
   );

   always_comb begin
      ps_nxt = ps_q;
      ps_nxt[PS_EXCM_BIT] = 1'b1;
      if (route == RT_HIGH) ps_nxt[LVL_W-1:0] = pend_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= RESET_VEC;
         ps_q    <= PS_RST;
         vb_q    <= VECBASE_RST;
         pend_q  <= '0;
         cause_q <= '0;
         taken_q <= 1'b0;
      end else begin
         pend_q  <= pend_level_i;
         taken_q <= accept;
         if (vb_wr_i) vb_q <= vb_wdata_i;
         if (accept) begin
            pc_q <= vec;
            ps_q <= ps_nxt;
            if (route != RT_HIGH) cause_q <= CAUSE_L1;
         end else begin
            if (pc_wr_i) pc_q <= pc_wdata_i;
            if (ps_wr_i) ps_q <= ps_wdata_i;
         end
      end
   end

   assign pc_o       = pc_q;
   assign ps_o       = ps_q;
   assign vecbase_o  = vb_q;
   assign exccause_o = cause_q;
   assign taken_o    = taken_q;

endmodule

// File: rtl/irq_dispatch_chk.sv
`timescale 1ns/1ps
module irq_dispatch_chk #(
   parameter int ADDR_W   = 32,
   parameter int CAUSE_W  = 6,
   parameter int L1_CAUSE = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               take_i,
   input logic               pc_wr_i,
   input logic               vb_wr_i,
   input logic [ADDR_W-1:0]  pc_o,
   input logic [7:0]         ps_o,
   input logic [ADDR_W-1:0]  vecbase_o,
   input logic [CAUSE_W-1:0] exccause_o,
   input logic               taken_o
);

   // no strobe, no pulse on the following cycle
   assert_no_spurious_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !take_i |=> !taken_o);

   // any accepted entry leaves exception mode set
   assert_excm_after_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
      taken_o |-> ps_o[4]);

   // PC only moves on a take or a core write
   assert_pc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!take_i && !pc_wr_i) |=> $stable(pc_o));

   // vector base only moves on its write strobe
   assert_vecbase_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !vb_wr_i |=> $stable(vecbase_o));

   // cause changes only with an entry, and only to the level-one code
   assert_cause_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(exccause_o) |-> (taken_o && exccause_o == CAUSE_W'(L1_CAUSE)));

endmodule

bind irq_dispatch irq_dispatch_chk #(
   .ADDR_W   (ADDR_W),
   .CAUSE_W  (CAUSE_W),
   .L1_CAUSE (L1_CAUSE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .take_i     (take_i),
   .pc_wr_i    (pc_wr_i),
   .vb_wr_i    (vb_wr_i),
   .pc_o       (pc_o),
   .ps_o       (ps_o),
   .vecbase_o  (vecbase_o),
   .exccause_o (exccause_o),
   .taken_o    (taken_o)
);

// File: tb/sim_irq_dispatch.sv
`timescale 1ns/1ps
module sim_irq_dispatch;

   localparam int AW   = 32;
   localparam int NL   = 6;
   localparam int NI   = 32;
   localparam int CW   = 6;
   localparam int EXL  = 0;
   localparam logic [AW-1:0] RST_PC  = 32'h5000_0000;
   localparam logic [AW-1:0] VB_RST  = 32'h4000_0000;
   localparam logic [AW-1:0] O_KERN  = 32'h300;
   localparam logic [AW-1:0] O_USER  = 32'h340;
   localparam logic [AW-1:0] O_DBL   = 32'h3C0;
   localparam logic [AW-1:0] O_HIGH  = 32'h180;
   localparam logic [AW-1:0] O_STEP  = 32'h40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic              take_i = 0;
   logic [3:0]        pend_level_i = 0;
   logic [NI-1:0]     intset_i = 0, intenable_i = 0;
   logic [NI-1:0]     mask [NL];
   logic [NL*NI-1:0]  level_mask_i;
   logic              pc_wr_i = 0, ps_wr_i = 0, vb_wr_i = 0;
   logic [AW-1:0]     pc_wdata_i = 0, vb_wdata_i = 0;
   logic [7:0]        ps_wdata_i = 0;
   logic [AW-1:0]     pc_o, depc_o, vecbase_o;
   logic [7:0]        ps_o;
   logic [NL*AW-1:0]  epc_o;
   logic [(NL-1)*8-1:0] eps_o;
   logic [CW-1:0]     exccause_o;
   logic              taken_o;

   always_comb begin
      for (int l = 0; l < NL; l++) level_mask_i[l*NI +: NI] = mask[l];
   end

   irq_dispatch u0 (
      .clk(clk), .rst_n(rst_n), .take_i(take_i), .pend_level_i(pend_level_i),
      .intset_i(intset_i), .intenable_i(intenable_i), .level_mask_i(level_mask_i),
      .pc_wr_i(pc_wr_i), .pc_wdata_i(pc_wdata_i), .ps_wr_i(ps_wr_i),
      .ps_wdata_i(ps_wdata_i), .vb_wr_i(vb_wr_i), .vb_wdata_i(vb_wdata_i),
      .pc_o(pc_o), .ps_o(ps_o), .epc_o(epc_o), .eps_o(eps_o), .depc_o(depc_o),
      .exccause_o(exccause_o), .vecbase_o(vecbase_o), .taken_o(taken_o)
   );

   // requirement-level model
   logic [AW-1:0] m_pc, m_vb, m_depc;
   logic [7:0]    m_ps;
   logic [3:0]    m_pend;
   logic [CW-1:0] m_cause;
   logic          m_taken;
   logic [AW-1:0] m_epc [1:NL];
   logic [7:0]    m_eps [2:NL];

   function automatic logic [3:0] cur_of(input logic [7:0] ps);
      if (ps[4] && ps[3:0] < 4'(EXL)) return 4'(EXL);
      return ps[3:0];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pc = RST_PC; m_ps = 8'h1F; m_vb = VB_RST; m_depc = '0;
         m_pend = '0; m_cause = '0; m_taken = 1'b0;
         for (int l = 1; l <= NL; l++) m_epc[l] = '0;
         for (int l = 2; l <= NL; l++) m_eps[l] = '0;
      end else begin
         logic acc;
         logic [3:0] lv;
         lv  = m_pend;
         acc = take_i && lv >= 4'd1 && lv <= 4'(NL) && lv > cur_of(m_ps) &&
               |(mask[lv-4'd1] & intset_i & intenable_i);
         if (acc) begin
            if (lv >= 4'd2) begin
               m_epc[lv] = m_pc;
               m_eps[lv] = m_ps;
               m_pc = m_vb + O_HIGH + AW'(lv - 4'd2) * O_STEP;
               m_ps = {m_ps[7:5], 1'b1, lv};
            end else begin
               m_cause = CW'(4);
               if (m_ps[4]) begin
                  m_depc = m_pc;
                  m_pc = m_vb + O_DBL;
               end else begin
                  m_epc[1] = m_pc;
                  m_pc = m_vb + (m_ps[5] ? O_USER : O_KERN);
               end
               m_ps[4] = 1'b1;
            end
         end else begin
            if (pc_wr_i) m_pc = pc_wdata_i;
            if (ps_wr_i) m_ps = ps_wdata_i;
         end
         m_taken = acc;
         m_pend = pend_level_i;
         if (vb_wr_i) m_vb = vb_wdata_i;
      end
   end

   int nchk = 0, nfail = 0;
   bit done = 0;

   task automatic chk(input string tag, input string what,
                      input logic [AW-1:0] act, input logic [AW-1:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk(tag, "taken", AW'(taken_o), AW'(m_taken));
      chk(tag, "pc", pc_o, m_pc);
      chk(tag, "ps", AW'(ps_o), AW'(m_ps));
      chk(tag, "depc", depc_o, m_depc);
      chk(tag, "cause", AW'(exccause_o), AW'(m_cause));
      chk(tag, "vecbase", vecbase_o, m_vb);
      for (int l = 1; l <= NL; l++) chk(tag, "epc", epc_o[(l-1)*AW +: AW], m_epc[l]);
      for (int l = 2; l <= NL; l++) chk(tag, "eps", AW'(eps_o[(l-2)*8 +: 8]), AW'(m_eps[l]));
   endtask

   // one clock with the currently driven inputs, then check and clear strobes
   task automatic step(input string tag);
      @(posedge clk);
      @(negedge clk);
      compare(tag);
      take_i = 0; pc_wr_i = 0; ps_wr_i = 0; vb_wr_i = 0;
   endtask

   task automatic wr_ps(input logic [7:0] v, input string tag);
      ps_wr_i = 1; ps_wdata_i = v;
      step(tag);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int l = 0; l < NL; l++) mask[l] = '1;
      intset_i = '1; intenable_i = '1;
      repeat (3) @(negedge clk);
      compare("R1");
      rst_n = 1;

      // R12: load pending level, then R1: reset PS blocks it
      pend_level_i = 4'd3; step("R12");
      take_i = 1; step("R1");

      // R6 kernel entry from level 1
      wr_ps(8'h00, "R11");
      pend_level_i = 4'd1; step("R12");
      pc_wr_i = 1; pc_wdata_i = 32'h0000_1234; step("R11");
      take_i = 1; step("R6");
      // R8: EXCM now set, same level becomes a double exception
      pc_wr_i = 1; pc_wdata_i = 32'h0000_2000; step("R11");
      take_i = 1; step("R8");
      // R7 user entry
      wr_ps(8'h20, "R7");
      take_i = 1; step("R7");
      // R4/R5 high level entry
      wr_ps(8'h21, "R4");
      pend_level_i = 4'd4; step("R12");
      take_i = 1; step("R5");
      // R2: out-of-range level and empty mask
      wr_ps(8'h00, "R2");
      pend_level_i = 4'd7; step("R2");
      take_i = 1; step("R2");
      mask[1] = '0; pend_level_i = 4'd2; step("R2");
      take_i = 1; step("R2");
      mask[1] = '1;
      // R3: EXCM with level field 3 - level 3 refused, level 4 taken
      wr_ps(8'h13, "R3");
      pend_level_i = 4'd3; step("R3");
      take_i = 1; pend_level_i = 4'd4; step("R3");
      take_i = 1; step("R3");
      // R9: move the base, then take
      vb_wr_i = 1; vb_wdata_i = 32'h8000_0000; ps_wr_i = 1; ps_wdata_i = 8'h00;
      pend_level_i = 4'd6; step("R9");
      take_i = 1; step("R9");
      // R11: take collides with core writes
      wr_ps(8'h00, "R11");
      pend_level_i = 4'd2; step("R11");
      take_i = 1; pc_wr_i = 1; pc_wdata_i = 32'hDEAD_0000; ps_wr_i = 1; ps_wdata_i = 8'h00;
      step("R11");
      // R12: level changes in the take cycle; old level 2 is judged
      wr_ps(8'h00, "R12");
      take_i = 1; pend_level_i = 4'd5; step("R12");
      // R10: pulse drops
      step("R10");

      // constrained random traffic
      for (int i = 0; i < 3000; i++) begin
         take_i       = ($urandom % 3) == 0;
         pend_level_i = 4'($urandom % 9);
         intset_i     = $urandom | $urandom;
         intenable_i  = $urandom | $urandom;
         for (int l = 0; l < NL; l++) mask[l] = $urandom & $urandom & $urandom;
         if (($urandom % 4) == 0) begin
            ps_wr_i = 1;
            ps_wdata_i = {2'b00, 1'($urandom), 1'(($urandom % 3) == 0), 4'($urandom % 5)};
         end
         if (($urandom % 2) == 0) begin
            pc_wr_i = 1; pc_wdata_i = $urandom;
         end
         if (($urandom % 20) == 0) begin
            vb_wr_i = 1; vb_wdata_i = $urandom & 32'hFFFF_F000;
         end
         step("R2");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule